// File: doc/BRIEF.md
# Clock-Enable Register Slave on a Two-Wire Serial Bus

This block is a serial-bus target, compatible with SMBus. It lets a host program the output enables of a clock generator. It samples the bus clock and data lines on the system clock and recognises start, repeated-start and stop conditions. It accepts frames for one fixed 7-bit address. Two transfers are supported. A byte write sends an address, a command code and one data byte. A byte read sends an address and a command code, then a repeated start, the address again with the read bit, and finally one byte returned by the target.

The command code selects one of a small bank of 8-bit registers. Every bit of the bank powers up as 1. Most bits enable one clock output and some positions are reserved. The enable bits drive `out_en_o` directly. Outputs that belong to differential pairs also drive a tri-state control in `hiz_o`, which goes high while the matching output is disabled. The data line output is open-drain, modelled as a pull-low enable.

Top module: `clk_en_smb_slave`

## Requirements
- R1: After reset every register reads 0xFF, `out_en_o` equals the defined-bit mask 0xF6EF, `hiz_o` is all zero and `sda_pull_o` is low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point, including a repeated start inside a frame, begins a new address phase.
- R3: The slave address is 0x69. The slave pulls SDA low in the ACK slot of a matching address. A non-matching address gets no ACK, and the rest of that frame has no effect until the next start or stop.
- R4: In a write frame (address with bit 0 equal to 0), the slave ACKs the command byte and the data byte. The data byte is stored into the register the command code selects.
- R5: In a read frame the slave drives the selected register MSB first in the 8 SCL periods after the address ACK. It then releases SDA for the master's NACK.
- R6: `out_en_o` bit 8*k+b carries bit b of register k. The reserved positions are register 0 bit 4 and register 1 bits 3 and 0, and they always drive 0.
- R7: `hiz_o` is 1 exactly at the differential positions (register 0 bits 7,6,5,3,2,1,0 and register 1 bits 6,2,1) whose enable bit is 0.
- R8: Reserved bits read back the value last written, or 1 after reset.
- R9: A command code of 2 or above is ACKed. A write to it changes nothing, and a read of it returns 0x00.
- R10: A stop that arrives in the middle of a byte aborts the frame and leaves every register unchanged.
- R11: `sda_pull_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| out_en_o | output | 16 | Clock output enables, 1 = enabled |
| hiz_o | output | 16 | Tri-state control for differential outputs, 1 = high impedance |

## Verification
The assertions assume that each SCL level lasts several system clocks longer than the synchronizer delay. They also assume that the master changes SDA only while SCL is low, except when it signals a start or a stop, and that SDA never moves against the slave's own pull. The bench master holds each quarter bit period for four clocks. It changes data only in the low phase and releases SDA during every ACK slot and every slave-driven bit. The random frames mix matching and non-matching addresses, existing and missing command codes, and writes and reads.

// File: rtl/clk_en_smb_pkg.sv
package clk_en_smb_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_DATA
  } smb_kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, synced, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= 2'b11;
    else         prev <= synced;
  end

  assign sda_o      = synced[0];
  assign scl_rise_o = ~prev[1] & synced[1];
  assign scl_fall_o = prev[1] & ~synced[1];
  assign start_o    = prev[1] & synced[1] & prev[0] & ~synced[0];
  assign stop_o     = prev[1] & synced[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import clk_en_smb_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REG_W-1:0] rdata_i,
  output logic [REG_W-1:0] cmd_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             sda_pull_o
);
  smb_state_e       st_q;
  smb_kind_e        kind_q;
  logic [REG_W-1:0] sh_q;
  logic [2:0]       cnt_q;
  logic             full_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; kind_q <= K_ADDR; sh_q <= '0; cnt_q <= '0;
      full_q <= 1'b0; rd_q <= 1'b0; cmd_o <= '0; wr_en_o <= 1'b0;
      wr_data_o <= '0; sda_pull_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st_q <= ST_IDLE; sda_pull_o <= 1'b0;
      end else if (start_i) begin
        st_q <= ST_RX; kind_q <= K_ADDR; cnt_q <= '0;
        full_q <= 1'b0; sda_pull_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i && !full_q) begin
              sh_q  <= {sh_q[REG_W-2:0], sda_i};
              cnt_q <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall_i && full_q) begin
              full_q <= 1'b0;
              cnt_q  <= '0;
              unique case (kind_q)
                K_ADDR: begin
                  if (sh_q[7:1] == SLAVE_ADDR) begin
                    rd_q <= sh_q[0]; sda_pull_o <= 1'b1; st_q <= ST_ACK;
                  end else begin
                    st_q <= ST_SKIP;
                  end
                end
                K_CMD: begin
                  cmd_o <= sh_q; sda_pull_o <= 1'b1; st_q <= ST_ACK;
                end
                default: begin
                  wr_en_o <= 1'b1; wr_data_o <= sh_q;
                  sda_pull_o <= 1'b1; st_q <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              if (kind_q == K_ADDR && rd_q) begin
                // first read bit goes out as the ACK slot ends
                st_q <= ST_TX; sh_q <= rdata_i;
                sda_pull_o <= ~rdata_i[REG_W-1]; cnt_q <= '0;
              end else begin
                sda_pull_o <= 1'b0;
                if (kind_q == K_ADDR) begin
                  kind_q <= K_CMD; st_q <= ST_RX;
                end else if (kind_q == K_CMD) begin
                  kind_q <= K_DATA; st_q <= ST_RX;
                end else begin
                  st_q <= ST_SKIP;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 3'd7) begin
                sda_pull_o <= 1'b0; st_q <= ST_MACK;
              end else begin
                cnt_q <= cnt_q + 3'd1;
                sh_q  <= {sh_q[REG_W-2:0], 1'b0};
                sda_pull_o <= ~sh_q[REG_W-2];
              end
            end
          end
          ST_MACK: if (scl_fall_i) st_q <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clk_en_regs.sv
module clk_en_regs
  import clk_en_smb_pkg::*;
#(
  parameter int NUM_REGS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [REG_W-1:0]          addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= '1;
      else if (wr_en_i && addr_i == REG_W'(g)) val_q <= wr_data_i;
    end
    assign regs_o[g*REG_W +: REG_W] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == REG_W'(i)) rdata_o = regs_o[i*REG_W +: REG_W];
  end
endmodule

// File: rtl/clk_en_smb_slave.sv
module clk_en_smb_slave
  import clk_en_smb_pkg::*;
#(
  parameter logic [6:0]              SLAVE_ADDR  = 7'h69,
  parameter int                      NUM_REGS    = 2,
  parameter int                      SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0]   DEF_MASK    = 16'hF6EF,
  parameter logic [NUM_REGS*8-1:0]   DIFF_MASK   = 16'h46EF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_pull_o,
  output logic [NUM_REGS*REG_W-1:0] out_en_o,
  output logic [NUM_REGS*REG_W-1:0] hiz_o
);
  localparam int FLAT_W = NUM_REGS * REG_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det, wr_en;
  logic [REG_W-1:0]  cmd, wr_data, rdata;
  logic [FLAT_W-1:0] regs;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .rdata_i(rdata), .cmd_o(cmd), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .sda_pull_o
  );

  clk_en_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(cmd),
    .wr_data_i(wr_data), .rdata_o(rdata), .regs_o(regs)
  );

  assign out_en_o = regs & DEF_MASK;
  assign hiz_o    = ~regs & DEF_MASK & DIFF_MASK;
endmodule

// File: rtl/clk_en_smb_chk.sv
module clk_en_smb_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_fall_i,
  input logic         start_i,
  input logic         stop_i,
  input logic         sda_pull_i,
  input logic         wr_en_i,
  input logic [W-1:0] out_en_i
);
  a_r11_pull_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> $past(scl_fall_i));

  a_r11_pull_fall_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_i) |-> $past(scl_fall_i || start_i || stop_i));

  a_r2_cond_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_i, stop_i}));

  a_r4_write_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> sda_pull_i);

  a_r10_out_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_en_i) |-> $past(wr_en_i));
endmodule

bind clk_en_smb_slave clk_en_smb_chk #(.W(NUM_REGS*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall), .start_i(start_det),
  .stop_i(stop_det), .sda_pull_i(sda_pull_o), .wr_en_i(wr_en), .out_en_i(out_en_o)
);

// File: tb/clk_en_smb_slave_tb_top.sv
module clk_en_smb_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [6:0]  ADDR = 7'h69;
  localparam logic [15:0] DEF  = 16'hF6EF;
  localparam logic [15:0] DIFF = 16'h46EF;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [15:0] out_en, hiz;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0, viol = 0;
  logic [7:0] m [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_en_smb_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .out_en_o(out_en), .hiz_o(hiz)
  );

  // R11 monitor: the pull may not move while SCL is high
  logic pull_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_pull != pull_d) viol++;
    pull_d <= sda_pull;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(2*Q);
    sda_m = 1'b0; hold(2*Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl = 1'b1; hold(2*Q); sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); b = sda_line;
    hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit nb;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(nb);
    ack = ~nb;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(1'b1);
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] c);
    return (c < 8'd2) ? m[c[0]] : 8'h00;
  endfunction

  task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                          output bit a0, output bit a1, output bit a2);
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(c, a1);
    send_byte(d, a2);
    bus_stop();
    if (a == ADDR && c < 8'd2) m[c[0]] = d;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] c, output logic [7:0] d,
                         output bit a0, output bit a1, output bit a2);
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(c, a1);
    bus_start();
    send_byte({a, 1'b1}, a2);
    recv_byte(d);
    bus_stop();
  endtask

  task automatic check_outputs(input string req);
    logic [15:0] flat;
    flat = {m[1], m[0]};
    @(negedge clk);
    chk(out_en == (flat & DEF), {req, " R6 out_en"}, out_en, flat & DEF);
    chk(hiz == (~flat & DEF & DIFF), {req, " R7 hiz"}, hiz, ~flat & DEF & DIFF);
  endtask

  bit done = 1'b0;

  initial begin
    bit a0, a1, a2;
    logic [7:0] d;
    void'($urandom(32'd1357));
    m[0] = 8'hFF; m[1] = 8'hFF;
    hold(5); rst_n = 1'b1; hold(5);

    // R1 reset state
    chk(out_en == DEF, "R1 out_en", out_en, DEF);
    chk(hiz == 16'h0, "R1 hiz", hiz, 0);
    chk(sda_pull == 1'b0, "R1 sda", sda_pull, 0);

    // R5 R8 reset readback, R2 repeated start
    do_read(ADDR, 8'd1, d, a0, a1, a2);
    chk(a0 && a1 && a2, "R2 R3 read acks", {a0, a1, a2}, 3'b111);
    chk(d == 8'hFF, "R8 reg1 reset read", d, 8'hFF);

    // R9 missing register read
    do_read(ADDR, 8'd5, d, a0, a1, a2);
    chk(a1, "R9 cmd ack", a1, 1);
    chk(d == 8'h00, "R9 read zero", d, 0);

    // R4 R6 R8 write reg0 with only the reserved bit set
    do_write(ADDR, 8'd0, 8'h10, a0, a1, a2);
    chk(a0 && a1 && a2, "R4 write acks", {a0, a1, a2}, 3'b111);
    check_outputs("R4");
    do_read(ADDR, 8'd0, d, a0, a1, a2);
    chk(d == 8'h10, "R8 reserved readback", d, 8'h10);

    // R9 write to missing register discarded
    do_write(ADDR, 8'd7, 8'h00, a0, a1, a2);
    chk(a1 && a2, "R9 write acks", {a1, a2}, 2'b11);
    check_outputs("R9");

    // R3 wrong address ignored
    do_write(7'h2A, 8'd1, 8'h00, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R3 no ack", {a0, a1, a2}, 0);
    check_outputs("R3");

    // R10 stop inside data byte
    bus_start(); send_byte({ADDR, 1'b0}, a0); send_byte(8'd1, a1);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check_outputs("R10 data abort");
    // R10 stop inside address byte, then a normal write
    bus_start(); for (int i = 0; i < 3; i++) put_bit(1'b1); bus_stop();
    do_write(ADDR, 8'd1, 8'h09, a0, a1, a2);
    chk(a0 && a2, "R10 recover acks", {a0, a2}, 2'b11);
    check_outputs("R10 recover");

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [6:0] a;
      logic [7:0] c, v;
      bit good;
      good = ($urandom % 5) != 0;
      a = good ? ADDR : 7'($urandom);
      if (a == ADDR) good = 1'b1;
      c = 8'($urandom % 4);
      v = 8'($urandom);
      if ($urandom % 2) begin
        do_write(a, c, v, a0, a1, a2);
        chk(a0 == good && a2 == good, "R3 R4 rnd write ack", {a0, a2}, {good, good});
        check_outputs("R4 rnd");
      end else begin
        do_read(a, c, d, a0, a1, a2);
        chk(a0 == good, "R3 rnd read ack", a0, good);
        if (good) chk(d == exp_rd(c), "R5 rnd read", d, exp_rd(c));
        else      chk(d == 8'hFF, "R3 rnd ignored read", d, 8'hFF);
      end
    end

    chk(viol == 0, "R11 pull while SCL high", viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule